// File: doc/BRIEF.md
# Configurable Multi-Precision Multiply-Add Block

This block is a fixed arithmetic slice for a datapath. Two 72-bit operand buses (144 input bits in all) feed a single multiplier array. A mode code repartitions that array into eight independent 9x9 multipliers, four 18x18 multipliers, or one 36x36 multiplier. Three post-processing modes reuse the four 18x18 products: they can feed two running accumulators, or be combined into two pair sums, or be combined into one four-term sum. A `sub` control turns the second term of each pair, or the accumulated term, into a subtraction.

Each 18x18 unit is built from four 9x9 partial products. In 9x9 mode, the two diagonal partial products of each unit serve as independent lane results. In 36x36 mode, the four units receive the four half-operand pairings, and their products are shifted and summed into a 72-bit result. All operands and products are unsigned. Sums, differences and accumulators wrap modulo two to the power of their field width.

The mode, `sub` and `clr` controls travel with each valid sample, so a control change matters only for the next sample that carries `in_valid`. The input stage register and the output stage register are each kept or removed by a parameter (`IN_REG`, `OUT_REG`). That choice trades two cycles of latency against a purely combinational path.

Top module: `mpm_mac_block`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_data` is 0 (with the output register present) and both accumulators hold 0.
- R2: Mode 0 (eight 9x9): for lane j = 0..7, `out_data[18j+17:18j]` equals `a_bus[9j+8:9j] * b_bus[9j+8:9j]`.
- R3: Mode 1 (four 18x18): for lane k = 0..3, `out_data[36k+35:36k]` equals `a_bus[18k+17:18k] * b_bus[18k+17:18k]`.
- R4: Mode 2 (one 36x36): `out_data[71:0]` equals `a_bus[35:0] * b_bus[35:0]`, and `out_data[143:72]` is 0.
- R5: Mode 3 (two multiply-accumulates): 38-bit accumulator k (k = 0,1) becomes acc ± P_k, where P_k is the lane-k 18x18 product and the sign is minus when `sub`=1. Accumulator 0 appears on `out_data[37:0]` and accumulator 1 on `out_data[109:72]`. All other bits are 0.
- R6: A mode-3 sample with `clr`=1 loads each accumulator with its product P_k, whatever `sub` is.
- R7: Mode 4 (two pair sums): `out_data[36:0]` = (P0 ± P1) mod 2^37 and `out_data[108:72]` = (P2 ± P3) mod 2^37, with minus when `sub`=1. All other bits are 0.
- R8: Mode 5 (four-term sum): `out_data[37:0]` = ((P0 ± P1) + (P2 ± P3)) mod 2^38, with both signs minus when `sub`=1. All other bits are 0.
- R9: With both stage registers present, the result of a sample taken at clock edge E appears with `out_valid`=1 after edge E+2. With both removed, the result and `out_valid` follow the inputs in the same cycle, and accumulators update at the next edge. Every sample yields exactly one result, in order.
- R10: While `in_valid`=0, changes on `mode`, `sub`, `clr` and the operand buses have no effect: `out_data` (with the output register present) and the accumulators keep their values. The next valid sample uses the controls it carries.
- R11: Samples in modes other than 3 leave both accumulators unchanged. A later mode-3 sample continues from the stored values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a sample on the operand and control inputs |
| mode | input | 3 | Mode code 0..5 (see R2..R8) |
| sub | input | 1 | Subtract the second term of each pair or the accumulated term |
| clr | input | 1 | Load accumulators with the product instead of accumulating |
| a_bus | input | 72 | First operand bus |
| b_bus | input | 72 | Second operand bus |
| out_valid | output | 1 | Marks a result on out_data |
| out_data | output | 144 | Result, field layout set by the sample's mode |

## Verification
The hardest situation to reach is a sample whose result depends on accumulator state that was built up across other modes and across idle cycles. During those idle cycles the control pins carry a clear and a subtract that must be ignored. The stimulus runs a mode-3 sequence, then interleaves pair-sum and 9x9 samples, then holds `in_valid` low while it toggles every control and operand. It then issues a plain accumulate, so any leak shows up as a wrong sum on the ports. Both a fully registered and a fully bypassed instance receive the same stream and are scored against one reference queue model.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    localparam int HALF_W    = 9;
    localparam int LANE_W    = 2 * HALF_W;
    localparam int NUM_UNITS = 4;
    localparam int NUM_NARROW = 2 * NUM_UNITS;
    localparam int BUS_W     = NUM_UNITS * LANE_W;
    localparam int OUT_W     = 2 * BUS_W;
    localparam int P9_W      = 2 * HALF_W;
    localparam int P18_W     = 2 * LANE_W;
    localparam int P36_W     = 4 * LANE_W;
    localparam int PAIR_W    = P18_W + 1;
    localparam int ACC_W     = P18_W + 2;
    localparam int NUM_ACC   = 2;
    localparam int ACC1_POS  = BUS_W;

    typedef enum logic [2:0] {
        MODE_X9   = 3'd0,
        MODE_X18  = 3'd1,
        MODE_X36  = 3'd2,
        MODE_MAC2 = 3'd3,
        MODE_SUM2 = 3'd4,
        MODE_SUM4 = 3'd5
    } mpm_mode_e;

    typedef struct packed {
        mpm_mode_e mode;
        logic      sub;
        logic      clr;
    } mpm_cfg_t;

    typedef struct packed {
        mpm_cfg_t           cfg;
        logic [BUS_W-1:0]   a;
        logic [BUS_W-1:0]   b;
    } mpm_sample_t;

    function automatic logic [ACC_W-1:0] add_or_sub(input logic [ACC_W-1:0] x,
                                                     input logic [ACC_W-1:0] y,
                                                     input logic neg);
        return neg ? (x - y) : (x + y);
    endfunction

endpackage

// File: rtl/mpm_unit18.sv
module mpm_unit18
    import mpm_pkg::*;
(
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    output logic [P18_W-1:0]  prod,
    output logic [P9_W-1:0]   diag_lo,
    output logic [P9_W-1:0]   diag_hi
);
    // quarter products: index bit0 picks the op_a half, bit1 the op_b half
    logic [P9_W-1:0] quarter [4];

    for (genvar q = 0; q < 4; q++) begin : g_quarter
        localparam int AH = q % 2;
        localparam int BH = q / 2;
        assign quarter[q] = P9_W'(op_a[AH*HALF_W +: HALF_W]) *
                            P9_W'(op_b[BH*HALF_W +: HALF_W]);
    end

    assign prod = P18_W'(quarter[0])
                + (P18_W'(quarter[1]) << HALF_W)
                + (P18_W'(quarter[2]) << HALF_W)
                + (P18_W'(quarter[3]) << LANE_W);

    assign diag_lo = quarter[0];
    assign diag_hi = quarter[3];
endmodule

// File: rtl/mpm_mult_array.sv
module mpm_mult_array
    import mpm_pkg::*;
(
    input  mpm_mode_e                         mode,
    input  logic [BUS_W-1:0]                  a,
    input  logic [BUS_W-1:0]                  b,
    output logic [NUM_NARROW-1:0][P9_W-1:0]   p9,
    output logic [NUM_UNITS-1:0][P18_W-1:0]   p18,
    output logic [P36_W-1:0]                  p72
);
    logic wide;
    assign wide = (mode == MODE_X36);

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        // in wide mode unit k takes a-half (k%2) and b-half (k/2) of the 36-bit operands
        localparam int AH = k % 2;
        localparam int BH = k / 2;
        logic [LANE_W-1:0] ua, ub;
        assign ua = wide ? a[AH*LANE_W +: LANE_W] : a[k*LANE_W +: LANE_W];
        assign ub = wide ? b[BH*LANE_W +: LANE_W] : b[k*LANE_W +: LANE_W];

        mpm_unit18 u_unit (
            .op_a    (ua),
            .op_b    (ub),
            .prod    (p18[k]),
            .diag_lo (p9[2*k]),
            .diag_hi (p9[2*k+1])
        );
    end

    assign p72 = P36_W'(p18[0])
               + (P36_W'(p18[1]) << LANE_W)
               + (P36_W'(p18[2]) << LANE_W)
               + (P36_W'(p18[3]) << (2*LANE_W));
endmodule

// File: rtl/mpm_post.sv
module mpm_post
    import mpm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              valid,
    input  mpm_cfg_t                          cfg,
    input  logic [NUM_NARROW-1:0][P9_W-1:0]   p9,
    input  logic [NUM_UNITS-1:0][P18_W-1:0]   p18,
    input  logic [P36_W-1:0]                  p72,
    output logic [OUT_W-1:0]                  out_next
);
    logic [NUM_ACC-1:0][ACC_W-1:0] acc_q;
    logic [NUM_ACC-1:0][ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0]              pair0, pair1, quad;
    logic                          acc_en;

    assign acc_en = valid && (cfg.mode == MODE_MAC2);

    always_comb begin
        pair0 = add_or_sub(ACC_W'(p18[0]), ACC_W'(p18[1]), cfg.sub);
        pair1 = add_or_sub(ACC_W'(p18[2]), ACC_W'(p18[3]), cfg.sub);
        quad  = pair0 + pair1;
        for (int k = 0; k < NUM_ACC; k++) begin
            acc_nx[k] = cfg.clr ? ACC_W'(p18[k])
                                : add_or_sub(acc_q[k], ACC_W'(p18[k]), cfg.sub);
        end
    end

    always_comb begin
        out_next = '0;
        unique case (cfg.mode)
            MODE_X9: begin
                for (int j = 0; j < NUM_NARROW; j++) out_next[j*P9_W +: P9_W] = p9[j];
            end
            MODE_X18: begin
                for (int k = 0; k < NUM_UNITS; k++) out_next[k*P18_W +: P18_W] = p18[k];
            end
            MODE_X36: out_next[P36_W-1:0] = p72;
            MODE_MAC2: begin
                out_next[ACC_W-1:0]           = acc_nx[0];
                out_next[ACC1_POS +: ACC_W]   = acc_nx[1];
            end
            MODE_SUM2: begin
                out_next[PAIR_W-1:0]          = pair0[PAIR_W-1:0];
                out_next[ACC1_POS +: PAIR_W]  = pair1[PAIR_W-1:0];
            end
            MODE_SUM4: out_next[ACC_W-1:0] = quad;
            default: out_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (acc_en) begin
            acc_q <= acc_nx;
        end
    end

    // R11: accumulators only move on an accumulate sample
    assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(acc_q));

    // R6: a clearing accumulate sample leaves the raw product in accumulator 0
    assert_acc_load_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_en && cfg.clr) |=> (acc_q[0] == ACC_W'($past(p18[0]))));
endmodule

// File: rtl/mpm_mac_block.sv
module mpm_mac_block
    import mpm_pkg::*;
#(
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic              sub,
    input  logic              clr,
    input  logic [BUS_W-1:0]  a_bus,
    input  logic [BUS_W-1:0]  b_bus,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    mpm_sample_t in_smp, s1_smp;
    logic        s1_valid;

    assign in_smp = '{cfg: '{mode: mpm_mode_e'(mode), sub: sub, clr: clr},
                      a: a_bus, b: b_bus};

    // input stage: controls and operands are captured only with a valid sample
    if (IN_REG) begin : g_in_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_valid <= 1'b0;
                s1_smp   <= '0;
            end else begin
                s1_valid <= in_valid;
                if (in_valid) s1_smp <= in_smp;
            end
        end
    end else begin : g_in_bypass
        assign s1_valid = in_valid;
        assign s1_smp   = in_smp;
    end

    logic [NUM_NARROW-1:0][P9_W-1:0]  arr_p9;
    logic [NUM_UNITS-1:0][P18_W-1:0]  arr_p18;
    logic [P36_W-1:0]                 arr_p72;
    logic [OUT_W-1:0]                 post_out;

    mpm_mult_array u_array (
        .mode (s1_smp.cfg.mode),
        .a    (s1_smp.a),
        .b    (s1_smp.b),
        .p9   (arr_p9),
        .p18  (arr_p18),
        .p72  (arr_p72)
    );

    mpm_post u_post (
        .clk      (clk),
        .rst      (rst),
        .valid    (s1_valid),
        .cfg      (s1_smp.cfg),
        .p9       (arr_p9),
        .p18      (arr_p18),
        .p72      (arr_p72),
        .out_next (post_out)
    );

    // R4: a zero 36-bit operand must give a zero wide product
    assert_wide_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (s1_smp.cfg.mode == MODE_X36 && s1_smp.a[2*LANE_W-1:0] == '0) |-> (arr_p72 == '0));

    if (OUT_REG) begin : g_out_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= s1_valid;
                if (s1_valid) out_data <= post_out;
            end
        end

        // R9: a result leaves the output stage one edge after the array sees it
        assert_out_stage_R9: assert property (@(posedge clk) disable iff (rst)
            s1_valid |=> out_valid);

        // R10: without a new result the output holds
        assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
            !out_valid |-> $stable(out_data));
    end else begin : g_out_bypass
        assign out_valid = s1_valid;
        assign out_data  = post_out;
    end

    if (IN_REG) begin : g_in_chk
        // R9: each sample reaches the array stage one edge after it is taken
        assert_in_stage_R9: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> s1_valid);
    end
endmodule

// File: tb/mpm_mac_block_test.sv
module mpm_mac_block_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] M_X9 = 3'd0, M_X18 = 3'd1, M_X36 = 3'd2,
                           M_MAC = 3'd3, M_SUM2 = 3'd4, M_SUM4 = 3'd5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         sub = 1'b0;
    logic         clr = 1'b0;
    logic [71:0]  a_bus = '0;
    logic [71:0]  b_bus = '0;
    logic         out_valid, out_valid_nr;
    logic [143:0] out_data, out_data_nr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [143:0] exp_q[$];
    string        tag_q[$];
    logic [143:0] exp_nr_q[$];
    string        tag_nr_q[$];
    logic [37:0]  macc [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpm_mac_block #(.IN_REG(1'b1), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sub(sub), .clr(clr),
        .a_bus(a_bus), .b_bus(b_bus), .out_valid(out_valid), .out_data(out_data));

    mpm_mac_block #(.IN_REG(1'b0), .OUT_REG(1'b0)) uut_nr (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sub(sub), .clr(clr),
        .a_bus(a_bus), .b_bus(b_bus), .out_valid(out_valid_nr), .out_data(out_data_nr));

    function automatic logic [143:0] model(input logic [2:0] m, input logic [71:0] a,
                                           input logic [71:0] b, input logic s, input logic c);
        logic [143:0] r;
        logic [35:0]  p [4];
        logic [37:0]  t0, t1;
        r = '0;
        for (int k = 0; k < 4; k++) p[k] = 36'(a[18*k +: 18]) * 36'(b[18*k +: 18]);
        t0 = s ? (38'(p[0]) - 38'(p[1])) : (38'(p[0]) + 38'(p[1]));
        t1 = s ? (38'(p[2]) - 38'(p[3])) : (38'(p[2]) + 38'(p[3]));
        case (m)
            M_X9:  for (int j = 0; j < 8; j++) r[18*j +: 18] = 18'(a[9*j +: 9]) * 18'(b[9*j +: 9]);
            M_X18: for (int k = 0; k < 4; k++) r[36*k +: 36] = p[k];
            M_X36: r[71:0] = 72'(a[35:0]) * 72'(b[35:0]);
            M_MAC: begin
                for (int k = 0; k < 2; k++)
                    macc[k] = c ? 38'(p[k]) : (s ? macc[k] - 38'(p[k]) : macc[k] + 38'(p[k]));
                r[37:0]   = macc[0];
                r[109:72] = macc[1];
            end
            M_SUM2: begin
                r[36:0]   = t0[36:0];
                r[108:72] = t1[36:0];
            end
            M_SUM4: r[37:0] = t0 + t1;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [143:0] act,
                         input logic [143:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [71:0] a, input logic [71:0] b,
                         input logic s, input logic c, input string req);
        logic [143:0] e;
        @(posedge clk);
        #1;
        mode = m; a_bus = a; b_bus = b; sub = s; clr = c; in_valid = 1'b1;
        e = model(m, a, b, s, c);
        exp_q.push_back(e);    tag_q.push_back(req);
        exp_nr_q.push_back(e); tag_nr_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitors, sampling away from the active edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result (registered)", out_data, '0);
            end else begin
                logic [143:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data === e, {t, " registered"}, out_data, e);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid_nr) begin
            if (exp_nr_q.size() == 0) begin
                check(1'b0, "R9 unexpected result (bypassed)", out_data_nr, '0);
            end else begin
                logic [143:0] e;
                string t;
                e = exp_nr_q.pop_front();
                t = tag_nr_q.pop_front();
                check(out_data_nr === e, {t, " bypassed"}, out_data_nr, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [143:0] held;
        macc[0] = '0;
        macc[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state at the ports
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 144'(out_valid), '0);
        check(out_data == '0, "R1 out_data after reset", out_data, '0);
        check(out_valid_nr == 1'b0, "R1 bypassed out_valid after reset", 144'(out_valid_nr), '0);

        // R9: latency of a lone sample
        drive(M_X18, 72'h0_0001_0002_0003_0004, 72'h0_0005_0006_0007_0008, 1'b0, 1'b0, "R3 lone");
        @(negedge clk);
        check(out_valid == 1'b0 && out_valid_nr == 1'b1, "R9 cycle 0 valids",
              {142'b0, out_valid, out_valid_nr}, 144'b01);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 after first edge", 144'(out_valid), '0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 after second edge", 144'(out_valid), 144'b1);
        idle(2);

        // R1: accumulators start at zero (first accumulate without clear)
        drive(M_MAC, 72'h0_0000_0000_0003_0010, 72'h0_0000_0000_0002_0020, 1'b0, 1'b0, "R1 acc zero");

        // R2: eight narrow lanes
        drive(M_X9, {8{9'h1FF}}, {8{9'h1FF}}, 1'b0, 1'b0, "R2 all ones");
        drive(M_X9, 72'h123456789ABCDEF012, 72'hFEDCBA9876543210AB, 1'b0, 1'b0, "R2 mixed");
        // R3: four 18x18 lanes
        drive(M_X18, {4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0, "R3 all ones");
        drive(M_X18, 72'h3_1415_9265_3589_7932, 72'h2_7182_8182_8459_0452, 1'b0, 1'b0, "R3 mixed");
        // R4: one 36x36
        drive(M_X36, {36'h0, 36'hF_FFFF_FFFF}, {36'h0, 36'hF_FFFF_FFFF}, 1'b0, 1'b0, "R4 all ones");
        drive(M_X36, 72'hAAA_9_8765_4321, 72'h555_1_2345_6789, 1'b0, 1'b0, "R4 upper ignored");
        drive(M_X36, 72'h0_0_0004_0000, 72'h0_0_0000_3FFFF, 1'b0, 1'b0, "R4 cross term");

        // R5 / R6: accumulate, subtract below zero, then clear
        drive(M_MAC, 72'h0_0000_0000_3FFFF_3FFFF, 72'h0_0000_0000_3FFFF_00100, 1'b0, 1'b0, "R5 add");
        drive(M_MAC, 72'h0_0000_0000_3FFFF_3FFFF, 72'h0_0000_0000_3FFFF_3FFFF, 1'b1, 1'b0, "R5 subtract wrap");
        drive(M_MAC, 72'h0_0000_0000_00007_00005, 72'h0_0000_0000_00009_00003, 1'b1, 1'b1, "R6 clear load");
        drive(M_MAC, 72'h0_0000_0000_00002_00002, 72'h0_0000_0000_00002_00002, 1'b0, 1'b0, "R6 after clear");

        // R11: other modes between accumulates
        drive(M_SUM2, 72'h3_FFFF_0001_2345_0010, 72'h3_FFFF_0002_1111_0100, 1'b0, 1'b0, "R7 add / R11");
        drive(M_SUM2, 72'h0_0010_3FFFF_0001_3FFFF, 72'h0_0010_3FFFF_0001_3FFFF, 1'b1, 1'b0, "R7 subtract");
        drive(M_X9, 72'h111222333444555666, 72'h777888999AAABBBCCC, 1'b1, 1'b1, "R2 / R11");
        drive(M_MAC, 72'h0_0000_0000_00010_00011, 72'h0_0000_0000_00003_00004, 1'b0, 1'b0, "R11 continue");

        // R8: four-term sums
        drive(M_SUM4, {4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0, "R8 add max");
        drive(M_SUM4, 72'h0_0001_3FFFF_0002_00001, 72'h0_0001_3FFFF_0002_00001, 1'b1, 1'b0, "R8 subtract");
        idle(4);

        // R10: control and operand activity without in_valid is ignored
        @(negedge clk);
        held = out_data;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            mode = (i == 0) ? M_MAC : M_SUM4;
            clr = 1'b1;
            sub = 1'b1;
            a_bus = 72'(({$urandom, $urandom, $urandom}));
            b_bus = 72'(({$urandom, $urandom, $urandom}));
            @(negedge clk);
            check(out_data === held && out_valid == 1'b0, "R10 output holds while idle", out_data, held);
        end
        drive(M_MAC, 72'h0_0000_0000_00005_00006, 72'h0_0000_0000_00007_00008, 1'b0, 1'b0, "R10 acc untouched");
        drive(M_X18, 72'h0_0003_0004_0005_0006, 72'h0_0007_0008_0009_000A, 1'b0, 1'b0, "R10 new mode taken");
        idle(6);

        check(exp_q.size() == 0 && exp_nr_q.size() == 0, "R9 every sample produced a result",
              144'(exp_q.size() + exp_nr_q.size()), '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule